// File: doc/BRIEF.md
# Conditional Add, Subtract and Select Unit

This block is a 32-bit datapath slice for a processor's execute stage. It covers six operations whose effect depends on a condition word: add, add-if-zero, subtract, subtract-if-zero, select and select-if-zero. The issuing logic supplies two operands, the condition word, a 3-bit operation code and a one-cycle enable. The unit returns the result combinationally in the same cycle.

The unit also keeps four status bits in a register: overflow, sticky overflow, advance-overflow and sticky advance-overflow. The arithmetic operations update these bits on the next rising clock edge, but only when their condition holds. When the condition fails, the first operand passes through unchanged and all four bits keep their values. The select operations never change the status bits. The sticky bits can only be set by the arithmetic, and only reset clears them.

Top module: `csu_unit`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge clears all four status bits. `flags` bit 0 is overflow, bit 1 is sticky overflow, bit 2 is advance-overflow and bit 3 is sticky advance-overflow.
- R2: The operation codes are: 0 add, 1 add-if-zero, 2 subtract, 3 subtract-if-zero, 4 select, 5 select-if-zero. For codes 0 and 2 the condition holds when `cond` is nonzero. For codes 1 and 3 it holds when `cond` is zero.
- R3: An add whose condition holds drives `result` with `opa + opb` modulo 2^32.
- R4: A subtract whose condition holds drives `result` with `opa - opb` modulo 2^32.
- R5: An arithmetic operation whose condition fails drives `result` with `opa`. All four status bits keep their values across the following edge, even when `en` is high.
- R6: An enabled arithmetic operation whose condition holds writes the overflow bit at the next edge. For add the value is bit 31 of `(r ^ opa) & ~(opa ^ opb)`. For subtract it is bit 31 of `(r ^ opa) & (opa ^ opb)`.
- R7: The same operation writes the advance-overflow bit at the next edge. The value is 1 when bits 31 and 30 of the result differ.
- R8: The same operation ORs the new overflow into sticky overflow and the new advance-overflow into sticky advance-overflow. No operation clears a sticky bit; only reset does.
- R9: Select gives `opa` when `cond` is nonzero and `opb` otherwise. Select-if-zero gives `opa` when `cond` is zero and `opb` otherwise. Neither changes any status bit.
- R10: With `en` low the status bits do not change. Codes 6 and 7 give `result = opa` and leave the status bits alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the status bits |
| en | input | 1 | One-cycle strobe that qualifies the status update |
| op | input | 3 | Operation code |
| opa | input | 32 | First operand, and the pass-through value |
| opb | input | 32 | Second operand |
| cond | input | 32 | Condition word |
| result | output | 32 | Combinational result |
| flags | output | 4 | Registered status bits {sticky adv, adv, sticky ovf, ovf} |

## Verification
The bench targets the signed boundaries: 0x7FFFFFFF plus 1, 0x7FFFFFFF minus 0xFFFFFFFF, and 0x80000000 minus 1. A design with the wrong sign term in the overflow formula would miss overflow on these cases, or report it on 0 minus 1. The bench also sets the sticky bits and then runs operations that produce no overflow. A design that copies the new value into the sticky bits would clear them at that point. Further cases use a zero and a nonzero condition word against both sense variants, an arithmetic operation whose condition fails while `en` is high, and a strobe-free cycle with overflowing operands. A design with inverted condition sense, or with flag writes that are not gated, would change `result` or the status bits in these cases.

// File: rtl/csu_pkg.sv
package csu_pkg;

   typedef enum logic [2:0] {
      OP_CADD  = 3'd0,
      OP_CADDZ = 3'd1,
      OP_CSUB  = 3'd2,
      OP_CSUBZ = 3'd3,
      OP_SEL   = 3'd4,
      OP_SELZ  = 3'd5
   } csu_op_e;

   typedef struct packed {
      logic sav;
      logic av;
      logic sv;
      logic v;
   } csu_flags_t;

endpackage

// File: rtl/csu_cond.sv
module csu_cond #(
   parameter int W = 32
) (
   input  logic [W-1:0] cond,
   input  logic         zero_sense,
   output logic         hit
);
   logic is_zero;

   assign is_zero = (cond == '0);
   assign hit     = zero_sense ? is_zero : !is_zero;
endmodule

// File: rtl/csu_arith.sv
module csu_arith #(
   parameter int W            = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] res,
   output logic         ov,
   output logic         aov
);
   localparam int MSB = W - 1;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [W-1:0] b_eff;
         assign b_eff = sub ? ~b : b;
         assign res   = a + b_eff + {{(W-1){1'b0}}, sub};
      end else begin : g_split
         logic [W-1:0] sum_v;
         logic [W-1:0] dif_v;
         assign sum_v = a + b;
         assign dif_v = a - b;
         assign res   = sub ? dif_v : sum_v;
      end
   endgenerate

   logic sign_moved;
   logic signs_differ;

   assign sign_moved   = res[MSB] ^ a[MSB];
   assign signs_differ = a[MSB] ^ b[MSB];
   assign ov           = sign_moved & (sub ? signs_differ : !signs_differ);
   assign aov          = res[MSB] ^ res[MSB-1];
endmodule

// File: rtl/csu_flagreg.sv
module csu_flagreg
   import csu_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       upd,
   input  logic       ov,
   input  logic       aov,
   output csu_flags_t q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (upd) begin
         q.v   <= ov;
         q.av  <= aov;
         q.sv  <= q.sv | ov;
         q.sav <= q.sav | aov;
      end
   end
endmodule

// File: rtl/csu_unit.sv
module csu_unit
   import csu_pkg::*;
#(
   parameter int W            = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [2:0]   op,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic [W-1:0] cond,
   output logic [W-1:0] result,
   output logic [3:0]   flags
);
   generate
      if (W < 2) begin : g_bad_width
         $error("csu_unit: W must be at least 2");
      end
   endgenerate

   logic         is_arith;
   logic         is_sel;
   logic         hit;
   logic         upd;
   logic         ov;
   logic         aov;
   logic [W-1:0] ares;
   csu_flags_t   fq;

   assign is_arith = (op[2] == 1'b0);
   assign is_sel   = (op == OP_SEL) || (op == OP_SELZ);

   csu_cond #(.W(W)) u_cond (
      .cond       (cond),
      .zero_sense (op[0]),
      .hit        (hit)
   );

   csu_arith #(.W(W), .SHARED_ADDER(SHARED_ADDER)) u_arith (
      .a   (opa),
      .b   (opb),
      .sub (op[1]),
      .res (ares),
      .ov  (ov),
      .aov (aov)
   );

   always_comb begin
      if (is_arith)
         result = hit ? ares : opa;
      else if (is_sel)
         result = hit ? opa : opb;
      else
         result = opa;
   end

   assign upd = en && is_arith && hit;

   csu_flagreg u_flags (
      .clk (clk),
      .rst (rst),
      .upd (upd),
      .ov  (ov),
      .aov (aov),
      .q   (fq)
   );

   assign flags = fq;
endmodule

// File: rtl/csu_unit_chk.sv
module csu_unit_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst,
   input logic         en,
   input logic [2:0]   op,
   input logic [W-1:0] opa,
   input logic [W-1:0] opb,
   input logic [W-1:0] cond,
   input logic [W-1:0] result,
   input logic [3:0]   flags
);
   logic c_true;
   logic arith;
   logic sel_any;

   assign c_true  = op[0] ? (cond == '0) : (cond != '0);
   assign arith   = (op < 3'd4);
   assign sel_any = (op == 3'd4) || (op == 3'd5);

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (flags == 4'd0));

   a_r5_false_passes_a: assert property (@(posedge clk) disable iff (rst)
      (arith && !c_true) |-> (result == opa));

   a_r5_false_holds_flags: assert property (@(posedge clk) disable iff (rst)
      (en && arith && !c_true) |=> $stable(flags));

   a_r8_sticky_ovf_kept: assert property (@(posedge clk) disable iff (rst)
      flags[1] |=> flags[1]);

   a_r8_sticky_adv_kept: assert property (@(posedge clk) disable iff (rst)
      flags[3] |=> flags[3]);

   a_r8_sticky_ovf_or: assert property (@(posedge clk) disable iff (rst)
      (en && arith && c_true) |=> (flags[1] == ($past(flags[1]) | flags[0])));

   a_r8_sticky_adv_or: assert property (@(posedge clk) disable iff (rst)
      (en && arith && c_true) |=> (flags[3] == ($past(flags[3]) | flags[2])));

   a_r9_sel_result: assert property (@(posedge clk) disable iff (rst)
      (op == 3'd4) |-> (result == ((cond != '0) ? opa : opb)));

   a_r9_sel_flags: assert property (@(posedge clk) disable iff (rst)
      (en && sel_any) |=> $stable(flags));

   a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(flags));
endmodule

bind csu_unit csu_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_csu_unit.sv
module tb_csu_unit;
   localparam int CLK_T = 10;
   localparam int NV    = 14;

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] c;
      logic [31:0] res;
      logic        v;
      logic        av;
   } vec_t;

   localparam vec_t TBL [NV] = '{
      '{3'd0, 32'd5,          32'd7,          32'd1,     32'd12,         1'b0, 1'b0}, // R3
      '{3'd0, 32'h7FFFFFFF,   32'd1,          32'd1,     32'h80000000,   1'b1, 1'b1}, // R3 R6 R7
      '{3'd2, 32'd10,         32'd3,          32'd1,     32'd7,          1'b0, 1'b0}, // R4 R8 sticky kept
      '{3'd2, 32'h7FFFFFFF,   32'hFFFFFFFF,   32'd3,     32'h80000000,   1'b1, 1'b1}, // R4 R6
      '{3'd2, 32'h80000000,   32'd1,          32'h100,   32'h7FFFFFFF,   1'b1, 1'b1}, // R4 R6 R7
      '{3'd1, 32'h40000000,   32'd0,          32'd0,     32'h40000000,   1'b0, 1'b1}, // R2 R7
      '{3'd3, 32'd0,          32'd1,          32'd0,     32'hFFFFFFFF,   1'b0, 1'b0}, // R2 R6
      '{3'd0, 32'h12345678,   32'h11111111,   32'd0,     32'h12345678,   1'b0, 1'b0}, // R5
      '{3'd1, 32'h7FFFFFFF,   32'd1,          32'd5,     32'h7FFFFFFF,   1'b0, 1'b0}, // R2 R5
      '{3'd4, 32'hAAAA0000,   32'h00005555,   32'd2,     32'hAAAA0000,   1'b0, 1'b0}, // R9
      '{3'd4, 32'hAAAA0000,   32'h00005555,   32'd0,     32'h00005555,   1'b0, 1'b0}, // R9
      '{3'd5, 32'hDEADBEEF,   32'h01234567,   32'd0,     32'hDEADBEEF,   1'b0, 1'b0}, // R9
      '{3'd5, 32'hDEADBEEF,   32'h01234567,   32'd9,     32'h01234567,   1'b0, 1'b0}, // R9
      '{3'd6, 32'hCAFEF00D,   32'h7FFFFFFF,   32'd1,     32'hCAFEF00D,   1'b0, 1'b0}  // R10
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic [2:0]  op  = 3'd0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [31:0] cond = '0;
   logic [31:0] result;
   logic [3:0]  flags;

   int n_chk = 0;
   int n_bad = 0;
   logic [3:0] mflags = 4'd0;

   always #(CLK_T/2) clk = ~clk;

   csu_unit dut (
      .clk (clk), .rst (rst), .en (en), .op (op),
      .opa (opa), .opb (opb), .cond (cond),
      .result (result), .flags (flags)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic run_vec(input vec_t t, input bit enb, input string req);
      bit arith;
      bit hit;
      @(negedge clk);
      op = t.op; opa = t.a; opb = t.b; cond = t.c; en = enb;
      #1;
      chk({req, " result"}, result, t.res);
      arith = (t.op < 3'd4);
      hit   = t.op[0] ? (t.c == 0) : (t.c != 0);
      @(posedge clk);
      #1 en = 1'b0;
      if (enb && arith && hit) begin
         mflags[0] = t.v;
         mflags[2] = t.av;
         mflags[1] = mflags[1] | t.v;
         mflags[3] = mflags[3] | t.av;
      end
      @(negedge clk);
      chk({req, " flags"}, {28'd0, flags}, {28'd0, mflags});
   endtask

   initial begin
      #(CLK_T * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset flags", {28'd0, flags}, 32'd0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         run_vec(TBL[i], 1'b1, "R2-table");
      end

      // R10: no strobe, overflowing operands must not touch the flags
      run_vec('{3'd0, 32'd1, 32'd1, 32'd1, 32'd2, 1'b0, 1'b0}, 1'b1, "R3 clear v");
      run_vec('{3'd0, 32'h7FFFFFFF, 32'd1, 32'd1, 32'h80000000, 1'b1, 1'b1}, 1'b0, "R10 idle");

      // R1: reset in mid-run clears sticky bits too
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1 rst = 1'b0;
      mflags = 4'd0;
      @(negedge clk);
      chk("R1 mid-run reset", {28'd0, flags}, 32'd0);

      // R5: sticky and plain bits set, then a failed condition holds all of them
      run_vec('{3'd2, 32'h80000000, 32'd1, 32'd1, 32'h7FFFFFFF, 1'b1, 1'b1}, 1'b1, "R6 set");
      run_vec('{3'd2, 32'd1, 32'd1, 32'd0, 32'd1, 1'b0, 1'b0}, 1'b1, "R5 hold");
      run_vec('{3'd3, 32'd4, 32'd4, 32'd0, 32'd0, 1'b0, 1'b0}, 1'b1, "R8 sticky");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule